// File: doc/BRIEF.md
# Reset line controller

A register-mapped peripheral that drives up to 128 separate reset outputs, one per target block, and reports back the state each line has actually reached inside its target clock domain. Software puts a line into reset by writing a 1 to its bit in one of four control words and releases it by writing a 0. The control words read back what was last written, so a single bit can be changed with read-modify-write. Four status words report the settled state of every line.

Each status bit is taken from a two-flop synchroniser running on the line's own domain clock. Line i belongs to domain i mod NUM_DOMAINS. A domain enable input models clock gating. While a domain is gated, its synchronisers hold, so its status bits never reach the new value and a polling loop in software can time out instead of hanging. The value a status bit takes for a line in reset is fixed per line by the parameter ASSERTED_STS. Most lines read 0 in reset and 1 when released; a few read the other way.

Register accesses use a request channel with valid/ready and a read response of fixed latency. A request transfers on a rising clock edge where req_valid and req_ready are both high. req_ready is low during reset and high from the first edge after reset onwards. The requester holds its request until that edge. The response has no back-pressure: rsp_valid is high for exactly one cycle, one cycle after a read transfers, and the requester must accept it then.

Top module: `rst_line_ctrl`

## Requirements
- R1: After reset, every implemented line is in reset. rst_out is all ones, and the control words read 1 for every implemented line. Status reads ASSERTED_STS for implemented lines as soon as the domain clocks run.
- R2: Writing a control word (byte offsets 0x00, 0x04, 0x08, 0x0C for words 0..3) sets line 32*m+n from bit n of word m, with 1 meaning in reset. rst_out changes on the edge that accepts the write and holds otherwise. A read returns the last value written.
- R3: Status words sit at byte offsets 0x10..0x1C, with bit n of status word m belonging to line 32*m+n. For a settled line, the status bit equals ASSERTED_STS[line] when the line is in reset and its inverse when the line is released.
- R4: A status bit follows rst_out through two flops on the line's domain clock. It changes no earlier than two domain edges after rst_out and has settled three cycles after the write.
- R5: While dom_en of a domain is low, the status bits of all lines in that domain hold their value. Once the enable returns, they settle.
- R6: A wide access (req_wide=1) addresses word w at its byte address in the low half and word w+1 in the high half, each half decoded independently. A narrow read returns 0 in bits 63:32.
- R7: Writes that land on a status word change no state.
- R8: Reads of offsets at or above 0x20, reads of lines at or above NUM_LINES, and reads of addresses not aligned to 4 bytes all return 0. Writes to those addresses change nothing.
- R9: rsp_valid rises exactly one cycle after an accepted read, carrying the data, and stays low after writes and idle cycles.
- R10: req_ready is low in reset and high from the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can transfer |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access spanning two words |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data; low half goes to word w, high half to word w+1 |
| rsp_valid | output | 1 | Read data valid, one cycle after the read transfers |
| rsp_rdata | output | 64 | Read data |
| dom_clk | input | NUM_DOMAINS | Target domain clocks |
| dom_en | input | NUM_DOMAINS | Domain clock running (0 = gated) |
| rst_out | output | NUM_LINES | Registered reset lines, 1 = in reset |

## Verification
The bench gates one domain, releases a whole word of lines and reads status. A design whose status followed the control register directly, ignoring the domain clock, would report every line released while the gated lines are still held. Lines in the inverted-polarity set are checked in both states; a design that applied one polarity to all lines would misreport them. Wide accesses that straddle the control and status banks, writes to status words, unaligned and unmapped addresses, and lines past NUM_LINES are all exercised. A decoder that let either half of a wide access act on the other, or stored bits for lines that do not exist, would read back non-zero data where zero is expected.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int unsigned WORD_BITS   = 32;
  localparam int unsigned MAX_LINES   = 128;
  localparam int unsigned BANK_WORDS  = MAX_LINES / WORD_BITS;
  localparam int unsigned NREG_WORDS  = 2 * BANK_WORDS;
  localparam int unsigned SEL_W       = $clog2(NREG_WORDS);

  // mask with one bit set for every implemented line
  function automatic logic [MAX_LINES-1:0] impl_mask(input int unsigned n);
    logic [MAX_LINES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_LINES; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/rlc_ctrl_regs.sv
module rlc_ctrl_regs
  import rlc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 100,
  parameter int unsigned WIDX_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WIDX_W-1:0]        wr_word,
  input  logic                     wr_wide,
  input  logic [2*WORD_BITS-1:0]   wr_data,
  output logic [MAX_LINES-1:0]     ctrl_bits
);
  localparam logic [MAX_LINES-1:0] IMPL = impl_mask(NUM_LINES);

  logic [WIDX_W:0] lo_idx;
  logic [WIDX_W:0] hi_idx;

  assign lo_idx = {1'b0, wr_word};
  assign hi_idx = lo_idx + 1'b1;

  for (genvar k = 0; k < BANK_WORDS; k++) begin : g_word
    localparam logic [WORD_BITS-1:0] KEEP = IMPL[k*WORD_BITS +: WORD_BITS];
    logic                 hit_lo;
    logic                 hit_hi;
    logic [WORD_BITS-1:0] word_q;
    logic [WORD_BITS-1:0] word_d;

    assign hit_lo = wr_en && (lo_idx == (WIDX_W+1)'(k));
    assign hit_hi = wr_en && wr_wide && (hi_idx == (WIDX_W+1)'(k));

    always_comb begin
      word_d = word_q;
      if (hit_lo)      word_d = wr_data[WORD_BITS-1:0];
      else if (hit_hi) word_d = wr_data[2*WORD_BITS-1:WORD_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= KEEP;
      else        word_q <= word_d & KEEP;
    end

    assign ctrl_bits[k*WORD_BITS +: WORD_BITS] = word_q;
  end
endmodule

// File: rtl/rlc_line_sync.sv
module rlc_line_sync #(
  parameter int unsigned NUM_LINES   = 100,
  parameter int unsigned NUM_DOMAINS = 4
) (
  input  logic                   rst_n,
  input  logic [NUM_DOMAINS-1:0] dom_clk,
  input  logic [NUM_DOMAINS-1:0] dom_en,
  input  logic [NUM_LINES-1:0]   line_req,
  output logic [NUM_LINES-1:0]   line_lvl
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int unsigned DOM = i % NUM_DOMAINS;
    logic stage1;
    logic stage2;

    // both stages come up in reset, matching the control register
    always_ff @(posedge dom_clk[DOM] or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b1;
        stage2 <= 1'b1;
      end else if (dom_en[DOM]) begin
        stage1 <= line_req[i];
        stage2 <= stage1;
      end
    end

    assign line_lvl[i] = stage2;
  end
endmodule

// File: rtl/rlc_read_port.sv
module rlc_read_port
  import rlc_pkg::*;
#(
  parameter int unsigned WIDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic                   rd_zero,
  input  logic [WIDX_W-1:0]      rd_word,
  input  logic                   rd_wide,
  input  logic [MAX_LINES-1:0]   ctrl_bits,
  input  logic [MAX_LINES-1:0]   stat_bits,
  output logic                   rsp_valid,
  output logic [2*WORD_BITS-1:0] rsp_rdata
);
  logic [WORD_BITS-1:0]   words [NREG_WORDS];
  logic [WIDX_W:0]        lo_idx;
  logic [WIDX_W:0]        hi_idx;
  logic [WORD_BITS-1:0]   lo_val;
  logic [WORD_BITS-1:0]   hi_val;
  logic [2*WORD_BITS-1:0] rdata_d;

  for (genvar k = 0; k < BANK_WORDS; k++) begin : g_map
    assign words[k]            = ctrl_bits[k*WORD_BITS +: WORD_BITS];
    assign words[k+BANK_WORDS] = stat_bits[k*WORD_BITS +: WORD_BITS];
  end

  always_comb begin
    lo_idx = {1'b0, rd_word};
    hi_idx = lo_idx + 1'b1;
    lo_val = '0;
    hi_val = '0;
    if (lo_idx < (WIDX_W+1)'(NREG_WORDS)) lo_val = words[lo_idx[SEL_W-1:0]];
    if (rd_wide && (hi_idx < (WIDX_W+1)'(NREG_WORDS))) hi_val = words[hi_idx[SEL_W-1:0]];
    rdata_d = rd_zero ? '0 : {hi_val, lo_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
  import rlc_pkg::*;
#(
  parameter int unsigned          NUM_LINES    = 100,
  parameter int unsigned          NUM_DOMAINS  = 4,
  parameter int unsigned          ADDR_W       = 8,
  parameter logic [MAX_LINES-1:0] ASSERTED_STS = 128'h0000_0000_0000_0010_0000_0300_0000_0009
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic                   req_wide,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [63:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [63:0]            rsp_rdata,
  input  logic [NUM_DOMAINS-1:0] dom_clk,
  input  logic [NUM_DOMAINS-1:0] dom_en,
  output logic [NUM_LINES-1:0]   rst_out
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic                 ready_q;
  logic                 accept;
  logic                 aligned;
  logic [WIDX_W-1:0]    word_idx;
  logic [MAX_LINES-1:0] ctrl_bits;
  logic [MAX_LINES-1:0] stat_bits;
  logic [NUM_LINES-1:0] line_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign word_idx  = req_addr[ADDR_W-1:2];

  rlc_ctrl_regs #(
    .NUM_LINES (NUM_LINES),
    .WIDX_W    (WIDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept && req_we && aligned),
    .wr_word   (word_idx),
    .wr_wide   (req_wide),
    .wr_data   (req_wdata),
    .ctrl_bits (ctrl_bits)
  );

  assign rst_out = ctrl_bits[NUM_LINES-1:0];

  rlc_line_sync #(
    .NUM_LINES   (NUM_LINES),
    .NUM_DOMAINS (NUM_DOMAINS)
  ) sync_i (
    .rst_n    (rst_n),
    .dom_clk  (dom_clk),
    .dom_en   (dom_en),
    .line_req (rst_out),
    .line_lvl (line_lvl)
  );

  // status: in reset reads the mask bit, released reads its inverse
  for (genvar i = 0; i < MAX_LINES; i++) begin : g_sts
    if (i < NUM_LINES) begin : g_impl
      assign stat_bits[i] = ~(line_lvl[i] ^ ASSERTED_STS[i]);
    end else begin : g_none
      assign stat_bits[i] = 1'b0;
    end
  end

  rlc_read_port #(
    .WIDX_W (WIDX_W)
  ) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (accept && !req_we),
    .rd_zero   (!aligned),
    .rd_word   (word_idx),
    .rd_wide   (req_wide),
    .ctrl_bits (ctrl_bits),
    .stat_bits (stat_bits),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/rst_line_ctrl_chk.sv
module rst_line_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dom_clk0,
  input logic        dom_en0,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        req_wide,
  input logic        rsp_valid,
  input logic [31:0] rsp_hi,
  input logic        rst_out0,
  input logic        line_lvl0
);
  logic rd_acc;
  logic wr_acc;
  assign rd_acc = req_valid && req_ready && !req_we;
  assign wr_acc = req_valid && req_ready && req_we;

  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  p_narrow_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !req_wide) |=> (rsp_hi == 32'h0));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(rst_out0));

  p_ready_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready);

  p_gated_hold_r5: assert property (@(posedge dom_clk0) disable iff (!rst_n)
    !dom_en0 |=> $stable(line_lvl0));

  p_two_stage_r4: assert property (@(posedge dom_clk0) disable iff (!rst_n)
    ($changed(line_lvl0) && $past(dom_en0) && $past(dom_en0, 2))
      |-> (line_lvl0 == $past(rst_out0, 2)));
endmodule

bind rst_line_ctrl rst_line_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .dom_clk0  (dom_clk[0]),
  .dom_en0   (dom_en[0]),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_wide  (req_wide),
  .rsp_valid (rsp_valid),
  .rsp_hi    (rsp_rdata[63:32]),
  .rst_out0  (rst_out[0]),
  .line_lvl0 (line_lvl[0])
);

// File: tb/rst_line_ctrl_tb_top.sv
module rst_line_ctrl_tb_top;
  localparam int unsigned NL   = 100;
  localparam int unsigned ND   = 4;
  localparam logic [127:0] MASK = 128'h0000_0000_0000_0010_0000_0300_0000_0009;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic          req_wide = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic [ND-1:0] dom_en = '1;
  logic [ND-1:0] dom_clk;
  logic [NL-1:0] rst_out;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;
  logic [127:0] exp_ctrl;

  always #2.5 clk = ~clk;
  assign dom_clk = {ND{clk}};

  rst_line_ctrl #(.NUM_LINES(NL), .NUM_DOMAINS(ND), .ADDR_W(8), .ASSERTED_STS(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dom_clk(dom_clk), .dom_en(dom_en),
    .rst_out(rst_out)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // settled status bit of a line, all domains running
  function automatic logic sts_bit(input int unsigned idx, input logic in_rst);
    if (idx >= NL) return 1'b0;
    return in_rst ? MASK[idx] : ~MASK[idx];
  endfunction

  function automatic logic [31:0] exp_word(input int unsigned k);
    logic [31:0] v;
    v = '0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (k < 4) v[b] = exp_ctrl[k*32+b];
      else if (k < 8) v[b] = sts_bit((k-4)*32+b, exp_ctrl[((k-4)*32+b) % 128]);
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_read(input logic [7:0] a, input logic w);
    int unsigned lo;
    if (a[1:0] != 2'b00) return 64'h0;
    lo = int'(a >> 2);
    return {w ? exp_word(lo+1) : 32'h0, exp_word(lo)};
  endfunction

  task automatic model_word(input int unsigned k, input logic [31:0] v);
    if (k < 4) begin
      for (int unsigned b = 0; b < 32; b++) begin
        if (k*32+b < NL) exp_ctrl[k*32+b] = v[b];
      end
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wide = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    check("R9 no response after write", {127'h0, rsp_valid}, 128'h0);
    if (a[1:0] == 2'b00) begin
      model_word(int'(a >> 2), d[31:0]);
      if (w) model_word(int'(a >> 2) + 1, d[63:32]);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, input logic w, output logic [63:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wide = w;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 response one cycle after read", {127'h0, rsp_valid}, 128'h1);
    q = rsp_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic w);
    logic [63:0] q;
    bus_read(a, w, q);
    check(req, {64'h0, q}, {64'h0, exp_read(a, w)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] q;
    logic [31:0] gexp;
    int unsigned seed_set;
    seed_set = $urandom(32'd20240607);
    exp_ctrl = '0;
    for (int unsigned i = 0; i < NL; i++) exp_ctrl[i] = 1'b1;

    repeat (3) @(negedge clk);
    check("R10 ready low in reset", {127'h0, req_ready}, 128'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 ready high after reset", {127'h0, req_ready}, 128'h1);
    check("R1 rst_out all asserted", {28'h0, rst_out}, {28'h0, {NL{1'b1}}});
    read_check("R1 control words after reset", 8'h00, 1'b1);
    read_check("R1 control word 3 after reset", 8'h0C, 1'b0);
    read_check("R1 R3 status reads mask in reset", 8'h10, 1'b1);
    read_check("R1 R3 status high words in reset", 8'h18, 1'b1);

    // gated domain: release word 0 with domain 1 stopped
    dom_en = 4'b1101;
    settle();
    bus_write(8'h00, 1'b0, 64'h0);
    check("R2 rst_out released despite gating", {96'h0, rst_out[31:0]}, 128'h0);
    repeat (8) @(negedge clk);
    bus_read(8'h10, 1'b0, q);
    for (int unsigned b = 0; b < 32; b++) gexp[b] = sts_bit(b, (b % ND) == 1);
    check("R5 gated lines hold status", {96'h0, q[31:0]}, {96'h0, gexp});
    dom_en = 4'b1111;
    settle();
    read_check("R5 R3 status settles after ungating", 8'h10, 1'b0);

    // R4: status not yet changed right after the write, settled later
    bus_write(8'h04, 1'b0, 64'h0000_0000_0000_0000);
    bus_read(8'h14, 1'b0, q);
    for (int unsigned b = 0; b < 32; b++) gexp[b] = sts_bit(32+b, 1'b1);
    check("R4 status lags control", {96'h0, q[31:0]}, {96'h0, gexp});
    settle();
    read_check("R4 status settled", 8'h14, 1'b0);

    // wide accesses
    bus_write(8'h08, 1'b1, 64'h1234_5678_A5A5_0F0F);
    settle();
    read_check("R6 wide write to words 2 and 3", 8'h08, 1'b1);
    read_check("R8 lines past count read zero", 8'h0C, 1'b0);
    bus_write(8'h0C, 1'b1, 64'hFFFF_FFFF_0000_0005);
    settle();
    read_check("R6 R7 wide write straddling status", 8'h0C, 1'b1);

    // status write ignored
    bus_write(8'h10, 1'b0, 64'hFFFF_FFFF);
    settle();
    read_check("R7 status write ignored control", 8'h00, 1'b1);
    check("R7 rst_out unchanged", {28'h0, rst_out}, {28'h0, exp_ctrl[NL-1:0]});
    read_check("R7 status unchanged", 8'h10, 1'b0);

    // unmapped and misaligned
    bus_write(8'h20, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_write(8'h01, 1'b0, 64'hFFFF_FFFF);
    settle();
    check("R8 ignored writes keep rst_out", {28'h0, rst_out}, {28'h0, exp_ctrl[NL-1:0]});
    read_check("R8 unmapped read zero", 8'h20, 1'b1);
    read_check("R8 misaligned read zero", 8'h01, 1'b0);
    read_check("R8 high status word past count", 8'h1C, 1'b0);

    // constrained random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0]  a;
      logic        w;
      logic [63:0] d;
      a = 8'($urandom_range(0, 39));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      w = 1'($urandom_range(0, 1));
      d = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) begin
        bus_write(a, w, d);
        settle();
        check("R2 rst_out after random write", {28'h0, rst_out}, {28'h0, exp_ctrl[NL-1:0]});
      end else begin
        read_check("R2 R3 R6 random read", a, w);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule